// File: doc/BRIEF.md
# Shaped On/Off Amplitude Keying Ramp

This block multiplies a stream of signed output samples by a 12-bit unsigned amplitude factor, so that a carrier can be keyed on and off without abrupt edges in its envelope. The factor is chosen by two control inputs. With the enable low, the multiplier is bypassed and samples pass through at full scale. With the enable high, the factor comes either from an internal linear ramp or directly from a manual scale word that software or another block may rewrite on any cycle.

The internal ramp is an 8-bit programmable-rate prescaler that steps a saturating 12-bit amplitude counter. A keying input picks the direction: high ramps the amplitude up toward full scale, low ramps it down toward zero. The ramp-rate word sets how many clocks pass between amplitude steps, so the time for a full transition is 4095 steps times the prescaler period.

Both outputs, the scaled sample and the factor that was applied to it, come from registers and so follow their inputs by one clock.

Top module: `amp_key_shaper`

## Requirements
- R1: With `en_i` low, `sample_o` equals `sample_i` from the previous cycle unchanged and `scale_o` reads 4095, whatever `auto_i`, `manual_scale_i` and the ramp hold.
- R2: With `en_i` high and `auto_i` low, the applied factor is `manual_scale_i`; a new value written on any cycle takes effect on the next clock edge.
- R3: With `en_i` high and `auto_i` high, the applied factor is the current value of the internal amplitude ramp counter; the counter keeps running in every mode.
- R4: The prescaler is loaded with `rate_i` and counts down one per clock; on the clock where it holds 0 it issues one step pulse and reloads `rate_i`, so a rate value R gives one step every R+1 clocks and R = 0 gives a step on every clock. After reset the first step lands on the (R+1)-th rising edge.
- R5: The amplitude counter changes only on a step pulse, and then by exactly one.
- R6: `sample_o` is the signed product of `sample_i` and the zero-extended factor, arithmetically shifted right by 12 bits (rounding toward minus infinity); a factor of 0 gives 0 and a factor of 4095 gives the sample times 4095/4096.
- R7: With `key_i` high each step increments the counter, which saturates at 4095.
- R8: With `key_i` low each step decrements the counter, which saturates at 0.
- R9: While `rst` is high the counter is 0, `sample_o` and `scale_o` are 0, and the prescaler holds `rate_i`.
- R10: `sample_o` and `scale_o` change only at a clock edge and reflect the inputs and counter value present before that edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Multiplier enable; low bypasses at full scale |
| auto_i | input | 1 | High selects the internal ramp, low the manual scale |
| rate_i | input | 8 | Ramp-rate prescaler reload value |
| manual_scale_i | input | 12 | Manual amplitude factor |
| key_i | input | 1 | High ramps up, low ramps down |
| sample_i | input | 16 | Signed input sample |
| sample_o | output | 16 | Signed scaled sample, registered |
| scale_o | output | 12 | Factor applied to the sample in `sample_o` |

## Verification
The bound checker watches, on every clock, that the amplitude counter moves only after a step pulse and then by one, that it holds at 4095 while keyed up and at 0 while keyed down, that bypass passes the previous sample through with the factor at 4095, and that a zero manual factor silences the output. What only the bench scenarios show is the absolute ramp timing after reset for a given rate word, the exact arithmetic of the scaled sample for negative values and mid-range factors, and that a full up-then-down transition reaches and leaves both end points at the expected cycles.

// File: rtl/amp_key_pkg.sv
package amp_key_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RAMP   = 2'd1,
    MODE_MANUAL = 2'd2
  } scale_mode_e;
endpackage

// File: rtl/ramp_prescaler.sv
module ramp_prescaler #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  // pulse while the down-counter sits at zero
  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= rate_i;
    else if (tick_o) cnt_q <= rate_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/amp_ramp_counter.sv
module amp_ramp_counter #(
  parameter int SCALE_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic               up_i,
  output logic [SCALE_W-1:0] level_o
);
  localparam logic [SCALE_W-1:0] LVL_MAX = {SCALE_W{1'b1}};
  localparam logic [SCALE_W-1:0] LVL_MIN = '0;

  logic [SCALE_W-1:0] level_q;
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_MIN;
    end else if (step_i) begin
      if (up_i && level_q != LVL_MAX)       level_q <= level_q + 1'b1;
      else if (!up_i && level_q != LVL_MIN) level_q <= level_q - 1'b1;
    end
  end
endmodule

// File: rtl/scale_apply.sv
module scale_apply
  import amp_key_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  scale_mode_e              mode_i,
  input  logic [SCALE_W-1:0]       manual_i,
  input  logic [SCALE_W-1:0]       ramp_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic [SCALE_W-1:0]       scale_o
);
  localparam int PROD_W = DATA_W + SCALE_W + 1;
  localparam logic [SCALE_W-1:0] FULL = {SCALE_W{1'b1}};

  logic [SCALE_W-1:0]       sel_scale;
  logic signed [PROD_W-1:0] prod;
  logic signed [DATA_W-1:0] scaled;
  logic                     unused_prod_bits;

  always_comb begin
    case (mode_i)
      MODE_RAMP:   sel_scale = ramp_i;
      MODE_MANUAL: sel_scale = manual_i;
      default:     sel_scale = FULL;
    endcase
  end

  assign prod   = PROD_W'(sample_i) * PROD_W'($signed({1'b0, sel_scale}));
  // bits [SCALE_W +: DATA_W] equal the arithmetic shift by SCALE_W
  assign scaled = prod[SCALE_W +: DATA_W];
  assign unused_prod_bits = &{prod[PROD_W-1], prod[SCALE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= '0;
      scale_o  <= '0;
    end else begin
      scale_o  <= sel_scale;
      sample_o <= (mode_i == MODE_BYPASS) ? sample_i : scaled;
    end
  end
endmodule

// File: rtl/amp_key_shaper.sv
module amp_key_shaper
  import amp_key_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 12,
  parameter int RATE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic                     auto_i,
  input  logic [RATE_W-1:0]        rate_i,
  input  logic [SCALE_W-1:0]       manual_scale_i,
  input  logic                     key_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [DATA_W-1:0] sample_o,
  output logic [SCALE_W-1:0]       scale_o
);
  scale_mode_e        mode;
  logic               pre_tick;
  logic [SCALE_W-1:0] ramp_level;

  always_comb begin
    if (!en_i)       mode = MODE_BYPASS;
    else if (auto_i) mode = MODE_RAMP;
    else             mode = MODE_MANUAL;
  end

  ramp_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .rate_i (rate_i),
    .tick_o (pre_tick)
  );

  amp_ramp_counter #(.SCALE_W(SCALE_W)) u_ramp (
    .clk     (clk),
    .rst     (rst),
    .step_i  (pre_tick),
    .up_i    (key_i),
    .level_o (ramp_level)
  );

  scale_apply #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_mul (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .manual_i (manual_scale_i),
    .ramp_i   (ramp_level),
    .sample_i (sample_i),
    .sample_o (sample_o),
    .scale_o  (scale_o)
  );
endmodule

// File: rtl/amp_key_checker.sv
module amp_key_checker #(
  parameter int DATA_W  = 16,
  parameter int SCALE_W = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en_i,
  input logic                     auto_i,
  input logic                     key_i,
  input logic [SCALE_W-1:0]       manual_scale_i,
  input logic signed [DATA_W-1:0] sample_i,
  input logic signed [DATA_W-1:0] sample_o,
  input logic [SCALE_W-1:0]       scale_o,
  input logic                     tick,
  input logic [SCALE_W-1:0]       level
);
  localparam logic [SCALE_W-1:0] TOP = {SCALE_W{1'b1}};

  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level)); // R5

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (level == $past(level) + 1'b1 || level == $past(level) - 1'b1)); // R5

  AST_SAT_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (level == TOP && key_i) |=> (level == TOP)); // R7

  AST_SAT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && !key_i) |=> (level == '0)); // R8

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (sample_o == $past(sample_i) && scale_o == TOP)); // R1

  AST_ZERO_SCALE_MUTES: assert property (@(posedge clk) disable iff (rst)
    (en_i && !auto_i && manual_scale_i == '0) |=> (sample_o == '0)); // R6

  AST_RAMP_FACTOR: assert property (@(posedge clk) disable iff (rst)
    (en_i && auto_i) |=> (scale_o == $past(level))); // R3
endmodule

bind amp_key_shaper amp_key_checker #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .en_i           (en_i),
  .auto_i         (auto_i),
  .key_i          (key_i),
  .manual_scale_i (manual_scale_i),
  .sample_i       (sample_i),
  .sample_o       (sample_o),
  .scale_o        (scale_o),
  .tick           (pre_tick),
  .level          (ramp_level)
);

// File: tb/sim_amp_key_shaper.sv
module sim_amp_key_shaper;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               en_i = 1'b0;
  logic               auto_i = 1'b0;
  logic [7:0]         rate_i = 8'd0;
  logic [11:0]        manual_scale_i = 12'd0;
  logic               key_i = 1'b0;
  logic signed [15:0] sample_i = 16'sd0;
  logic signed [15:0] sample_o;
  logic [11:0]        scale_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  amp_key_shaper u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .auto_i(auto_i), .rate_i(rate_i),
    .manual_scale_i(manual_scale_i), .key_i(key_i), .sample_i(sample_i),
    .sample_o(sample_o), .scale_o(scale_o)
  );

  typedef struct packed {
    logic               en;
    logic               aut;
    logic [11:0]        scl;
    logic signed [15:0] smp;
    logic signed [15:0] exp_out;
    logic [11:0]        exp_scl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 12'd0,    16'sd1000,    16'sd1000,    12'd4095},
    '{1'b0, 1'b1, 12'd5,   -16'sd32768,  -16'sd32768,   12'd4095},
    '{1'b1, 1'b0, 12'd0,    16'sd12345,   16'sd0,       12'd0},
    '{1'b1, 1'b0, 12'd4095, 16'sd4096,    16'sd4095,    12'd4095},
    '{1'b1, 1'b0, 12'd2048, 16'sd1000,    16'sd500,     12'd2048},
    '{1'b1, 1'b0, 12'd2048,-16'sd1000,   -16'sd500,     12'd2048},
    '{1'b1, 1'b0, 12'd1024,-16'sd3,      -16'sd1,       12'd1024},
    '{1'b1, 1'b0, 12'd4095,-16'sd32768,  -16'sd32760,   12'd4095},
    '{1'b1, 1'b0, 12'd1,    16'sd32767,   16'sd7,       12'd1},
    '{1'b1, 1'b0, 12'd3000, 16'sd20000,   16'sd14648,   12'd3000}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R9: reset holds outputs at zero even in bypass with a live sample
    sample_i = 16'sd1234;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset scale_o", int'(scale_o), 0);
    check("R9 reset sample_o", int'(sample_o), 0);
    rst = 1'b0;

    // table walk: R1 bypass, R2 manual, R6 arithmetic, R10 latency
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      en_i = VECS[i].en;
      auto_i = VECS[i].aut;
      manual_scale_i = VECS[i].scl;
      sample_i = VECS[i].smp;
      if (i > 0) begin
        #1;
        check("R10 no change before edge", int'(sample_o), int'(VECS[i-1].exp_out));
      end
      @(posedge clk);
      @(negedge clk);
      check(VECS[i].en ? "R2/R6 manual sample_o" : "R1 bypass sample_o",
            int'(sample_o), int'(VECS[i].exp_out));
      check(VECS[i].en ? "R2 manual scale_o" : "R1 bypass scale_o",
            int'(scale_o), int'(VECS[i].exp_scl));
    end

    // R3/R4/R5/R7: rate 3 ramp up, factor k gives sample_o = k for sample 4096
    en_i = 1'b1; auto_i = 1'b1; key_i = 1'b1; rate_i = 8'd3; sample_i = 16'sd4096;
    do_reset();
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      check("R4 rate3 ramp scale_o", int'(scale_o), (n - 1) / 4);
      check("R3 ramp sample_o", int'(sample_o), (n - 1) / 4);
    end

    // R4 rate 0: step every clock
    rate_i = 8'd0;
    do_reset();
    for (int n = 1; n <= 10; n++) @(negedge clk);
    check("R4 rate0 scale_o", int'(scale_o), 9);
    // R7: saturate at 4095
    repeat (4100) @(negedge clk);
    check("R7 saturate top", int'(scale_o), 4095);
    repeat (10) @(negedge clk);
    check("R7 hold top", int'(scale_o), 4095);

    // R8: key low ramps down, saturates at 0
    key_i = 1'b0;
    @(negedge clk);
    check("R8 first edge shows old", int'(scale_o), 4095);
    @(negedge clk);
    check("R8 first decrement", int'(scale_o), 4094);
    repeat (4200) @(negedge clk);
    check("R8 saturate zero", int'(scale_o), 0);
    check("R6 zero factor sample", int'(sample_o), 0);
    repeat (5) @(negedge clk);
    check("R8 hold zero", int'(scale_o), 0);

    // R2/R3: manual overrides the ramp; R1 bypass ignores manual
    auto_i = 1'b0; manual_scale_i = 12'd77;
    @(negedge clk);
    check("R2 manual over ramp", int'(scale_o), 77);
    en_i = 1'b0; manual_scale_i = 12'd0; sample_i = -16'sd5;
    @(negedge clk);
    check("R1 bypass ignores manual", int'(sample_o), -5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule